// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block is the test and configuration port of a small programmable logic device. Behind one command channel it keeps three kinds of state: a 64-bit user signature, a stored configuration pattern that can be written and read back, and a bank of output registers that can each be forced to a chosen level before clocked operation starts. A one-bit security lock protects that state. Once the lock is set, pattern read-back, pattern writes, register preload and signature writes are all refused. Signature reads are still served.

Commands arrive over a valid/ready handshake. Each command carries a 3-bit opcode, an 8-bit index and a data word. Only one command is handled at a time. Every accepted command gets exactly one response pulse, which carries read data and an error flag. The lock can only be cleared by the erase command. Erase wipes the stored pattern one word per cycle and releases the lock on its last cycle.

Top module: `cfg_access_ctrl`

## Requirements
- R1: The signature is 64 bits, held as four 16-bit words selected by index 0 to 3, with word 0 holding the lowest bits. A word written with opcode 0 is returned by a later read with opcode 1 at the same index.
- R2: A signature read (opcode 1) succeeds with correct data whether or not the lock is set.
- R3: While locked, a pattern verify (opcode 3) is refused. While unlocked, it returns the word last written to that index by opcode 2.
- R4: While locked, a preload (opcode 4) is refused and no output register changes.
- R5: The lock (opcode 5) applies from the very next accepted command onward.
- R6: A preload with index i below 10 sets output register i to bit 0 of the data word and leaves every other output register unchanged.
- R7: The lock stays set until an erase (opcode 6) completes. Erase sets every pattern word to zero and clears the lock. Its response comes 16 cycles after that of a normal command.
- R8: A refused command answers with the error flag high for one cycle and zero read data, and it leaves all stored state unchanged.
- R9: `cmd_ready` is high only when the block is idle. A command accepted on a rising edge is answered on that same edge, except for erase. `rsp_valid` lasts exactly one cycle, and `cmd_ready` stays low during it.
- R10: While locked, a signature write (opcode 0) is refused and the stored word keeps its value.
- R11: The following are refused: a signature index of 4 or more, a pattern index of 16 or more, a preload index of 10 or more, and opcode 7.
- R12: After reset, the lock is clear, all output registers are 0, `cmd_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 3 | Opcode: 0 sig write, 1 sig read, 2 pattern write, 3 pattern verify, 4 preload, 5 lock, 6 erase, 7 reserved |
| cmd_idx | input | 8 | Word or register index |
| cmd_wdata | input | 16 | Write data; bit 0 is the preload level |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Command was refused |
| rsp_rdata | output | 16 | Read data, zero unless a permitted read |
| lock_o | output | 1 | Security lock state |
| preg_q | output | 10 | Output register bank |

## Verification
The assertions assume that `cmd_valid` is only raised with a defined opcode and index, and that reset is held for at least one edge before the first command. The pattern memory has no reset, so its contents are meaningful only after a write or an erase. For that reason the bench starts with an erase and only verifies pattern words it has written. Inputs are driven on the falling edge and held until the edge that accepts them, so every command meets these conditions.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [2:0] {
    OP_SIG_WR  = 3'd0,
    OP_SIG_RD  = 3'd1,
    OP_PAT_WR  = 3'd2,
    OP_PAT_RD  = 3'd3,
    OP_PRELOAD = 3'd4,
    OP_LOCK    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } cfg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESP  = 2'd1,
    ST_ERASE = 2'd2
  } cfg_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SIG  = 2'd1,
    SRC_PAT  = 2'd2
  } rsp_src_e;
endpackage

// File: rtl/cfg_pat_mem.sv
module cfg_pat_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/cfg_sig_store.sv
module cfg_sig_store #(
  parameter int DW       = 16,
  parameter int SIG_BITS = 64,
  localparam int WORDS   = SIG_BITS / DW,
  localparam int SAW     = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [SAW-1:0] widx,
  input  logic [DW-1:0]  wdata,
  input  logic [SAW-1:0] ridx,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] words_q [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
      rd_q <= '0;
    end else begin
      if (we) words_q[widx] <= wdata;
      rd_q <= words_q[ridx];
    end
  end

  assign rdata = rd_q;

  // R1
  sig_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> words_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/cfg_preload_bank.sv
module cfg_preload_bank #(
  parameter int NREG = 10,
  parameter int IW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [IW-1:0]   idx,
  input  logic            val,
  output logic [NREG-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else if (load && idx == IW'(i)) q[i] <= val;
    end

    // R6
    preload_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (load && idx == IW'(i)) |=> q[i] == $past(val));

    // R6
    other_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(load && idx == IW'(i)) |=> $stable(q[i]));
  end
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SIG_BITS  = 64,
  parameter int PAT_WORDS = 16,
  parameter int NREG      = 10,
  parameter int IW        = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [IW-1:0]   cmd_idx,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  output logic            lock_o,
  output logic [NREG-1:0] preg_q
);
  localparam int SIG_WORDS = SIG_BITS / DW;
  localparam int SAW       = $clog2(SIG_WORDS);
  localparam int PAW       = $clog2(PAT_WORDS);
  localparam logic [IW-1:0]  SIG_LIM  = IW'(SIG_WORDS);
  localparam logic [IW-1:0]  PAT_LIM  = IW'(PAT_WORDS);
  localparam logic [IW-1:0]  REG_LIM  = IW'(NREG);
  localparam logic [PAW-1:0] WIPE_END = PAW'(PAT_WORDS - 1);

  cfg_state_e     state_q;
  rsp_src_e       src_q;
  logic           lock_q;
  logic           rsp_valid_q;
  logic           rsp_err_q;
  logic [PAW-1:0] wipe_q;

  cfg_op_e        op;
  logic           accept;
  logic           refuse;
  logic           sig_we;
  logic           pat_we;
  logic           pl_load;
  logic [PAW-1:0] pat_waddr;
  logic [DW-1:0]  pat_wdata;
  logic [DW-1:0]  sig_rd;
  logic [DW-1:0]  pat_rd;

  assign op        = cfg_op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    unique case (op)
      OP_SIG_WR:            refuse = lock_q || (cmd_idx >= SIG_LIM);
      OP_SIG_RD:            refuse = (cmd_idx >= SIG_LIM);
      OP_PAT_WR, OP_PAT_RD: refuse = lock_q || (cmd_idx >= PAT_LIM);
      OP_PRELOAD:           refuse = lock_q || (cmd_idx >= REG_LIM);
      OP_LOCK, OP_ERASE:    refuse = 1'b0;
      default:              refuse = 1'b1;
    endcase
  end

  assign sig_we    = accept && (op == OP_SIG_WR) && !refuse;
  assign pl_load   = accept && (op == OP_PRELOAD) && !refuse;
  assign pat_we    = (accept && (op == OP_PAT_WR) && !refuse) || (state_q == ST_ERASE);
  assign pat_waddr = (state_q == ST_ERASE) ? wipe_q : cmd_idx[PAW-1:0];
  assign pat_wdata = (state_q == ST_ERASE) ? '0 : cmd_wdata;

  cfg_sig_store #(.DW(DW), .SIG_BITS(SIG_BITS)) u_sig (
    .clk   (clk),
    .rst   (rst),
    .we    (sig_we),
    .widx  (cmd_idx[SAW-1:0]),
    .wdata (cmd_wdata),
    .ridx  (cmd_idx[SAW-1:0]),
    .rdata (sig_rd)
  );

  cfg_pat_mem #(.DW(DW), .DEPTH(PAT_WORDS)) u_pat (
    .clk   (clk),
    .we    (pat_we),
    .waddr (pat_waddr),
    .wdata (pat_wdata),
    .raddr (cmd_idx[PAW-1:0]),
    .rdata (pat_rd)
  );

  cfg_preload_bank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .load (pl_load),
    .idx  (cmd_idx),
    .val  (cmd_wdata[0]),
    .q    (preg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      src_q       <= SRC_NONE;
      lock_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      wipe_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (op == OP_ERASE) begin
              state_q <= ST_ERASE;
              wipe_q  <= '0;
            end else begin
              state_q     <= ST_RESP;
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= refuse;
              if (refuse)                 src_q <= SRC_NONE;
              else if (op == OP_SIG_RD)   src_q <= SRC_SIG;
              else if (op == OP_PAT_RD)   src_q <= SRC_PAT;
              else                        src_q <= SRC_NONE;
              if (op == OP_LOCK) lock_q <= 1'b1;
            end
          end
        end
        ST_ERASE: begin
          wipe_q <= wipe_q + 1'b1;
          if (wipe_q == WIPE_END) begin
            lock_q      <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b0;
            src_q       <= SRC_NONE;
            state_q     <= ST_RESP;
          end
        end
        default: begin
          rsp_valid_q <= 1'b0;
          rsp_err_q   <= 1'b0;
          src_q       <= SRC_NONE;
          state_q     <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_SIG: rsp_rdata = sig_rd;
      SRC_PAT: rsp_rdata = pat_rd;
      default: rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign lock_o    = lock_q;

  // R9
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |=> !rsp_valid_q);

  // R9
  busy_during_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> !cmd_ready);

  // R8
  refused_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_q && rsp_err_q) |-> rsp_rdata == '0);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && state_q != ST_ERASE) |=> lock_q);

  // R10
  sig_guard_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> !sig_we);

  // R8
  pat_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && state_q != ST_ERASE) |-> !pat_we);

  // R4
  preload_guard_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(preg_q));

  // R5
  lock_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> !cmd_ready);
endmodule

// File: tb/sim_cfg_access_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_access_ctrl;
  localparam int DW = 16;
  localparam int NREG = 10;
  localparam int PATW = 16;

  typedef struct {
    logic          err;
    logic [DW-1:0] data;
    int            due;
    string         tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [2:0]      cmd_op = '0;
  logic [7:0]      cmd_idx = '0;
  logic [DW-1:0]   cmd_wdata = '0;
  logic            rsp_valid;
  logic            rsp_err;
  logic [DW-1:0]   rsp_rdata;
  logic            lock_o;
  logic [NREG-1:0] preg_q;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  exp_t exp_q[$];
  logic [NREG-1:0] preg_exp = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_access_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .lock_o(lock_o), .preg_q(preg_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int idx, input logic [DW-1:0] wd,
                       input logic e_err, input logic [DW-1:0] e_data,
                       input int lat, input string tag);
    exp_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_idx   = idx[7:0];
    cmd_wdata = wd;
    e.err = e_err; e.data = e_data; e.due = cyc + lat; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || !cmd_ready) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_err == e.err, {e.tag, " err"}, int'(rsp_err), int'(e.err));
        chk(rsp_rdata == e.data, {e.tag, " data"}, int'(rsp_rdata), int'(e.data));
        chk(cyc == e.due, {e.tag, " R9 latency"}, cyc, e.due);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(cmd_ready == 1'b1, "R12 ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R12 rsp_valid", int'(rsp_valid), 0);
    chk(lock_o == 1'b0, "R12 lock", int'(lock_o), 0);
    chk(preg_q == '0, "R12 preg", int'(preg_q), 0);

    // R7 erase latency and clean start
    issue(3'd6, 0, '0, 1'b0, '0, 1 + PATW, "R7 erase");
    // R9 ready low right after a normal accept
    issue(3'd1, 0, '0, 1'b0, '0, 1, "R9 read");
    chk(cmd_ready == 1'b0, "R9 ready low in rsp", int'(cmd_ready), 0);
    drain();

    // R1 signature words
    issue(3'd0, 0, 16'hA5A5, 1'b0, '0, 1, "R1 wr0");
    issue(3'd0, 1, 16'h1234, 1'b0, '0, 1, "R1 wr1");
    issue(3'd0, 2, 16'hFFFF, 1'b0, '0, 1, "R1 wr2");
    issue(3'd0, 3, 16'h0001, 1'b0, '0, 1, "R1 wr3");
    issue(3'd1, 0, '0, 1'b0, 16'hA5A5, 1, "R1 rd0");
    issue(3'd1, 1, '0, 1'b0, 16'h1234, 1, "R1 rd1");
    issue(3'd1, 2, '0, 1'b0, 16'hFFFF, 1, "R1 rd2");
    issue(3'd1, 3, '0, 1'b0, 16'h0001, 1, "R1 rd3");

    // R3 pattern write and verify, unlocked
    issue(3'd2, 0, 16'h0F0F, 1'b0, '0, 1, "R3 pwr0");
    issue(3'd2, 5, 16'hBEEF, 1'b0, '0, 1, "R3 pwr5");
    issue(3'd2, 15, 16'h8001, 1'b0, '0, 1, "R3 pwr15");
    issue(3'd3, 5, '0, 1'b0, 16'hBEEF, 1, "R3 prd5");
    issue(3'd3, 15, '0, 1'b0, 16'h8001, 1, "R3 prd15");
    issue(3'd3, 0, '0, 1'b0, 16'h0F0F, 1, "R3 prd0");
    issue(3'd3, 1, '0, 1'b0, 16'h0000, 1, "R3 prd1 erased");

    // R11 range and opcode refusals
    issue(3'd1, 4, '0, 1'b1, '0, 1, "R11 sig idx 4");
    issue(3'd3, 16, '0, 1'b1, '0, 1, "R11 pat idx 16");
    issue(3'd4, 10, 16'h1, 1'b1, '0, 1, "R11 preload idx 10");
    issue(3'd7, 0, '0, 1'b1, '0, 1, "R11 reserved op");
    issue(3'd2, 200, 16'h5555, 1'b1, '0, 1, "R11 pat wr idx 200");

    // R6 preload
    issue(3'd4, 3, 16'h1, 1'b0, '0, 1, "R6 pl3");
    issue(3'd4, 0, 16'h1, 1'b0, '0, 1, "R6 pl0");
    issue(3'd4, 9, 16'hFFFF, 1'b0, '0, 1, "R6 pl9");
    drain();
    preg_exp = 10'b10_0000_1001;
    chk(preg_q == preg_exp, "R6 preg set", int'(preg_q), int'(preg_exp));
    issue(3'd4, 3, 16'hFFFE, 1'b0, '0, 1, "R6 pl3 low");
    drain();
    preg_exp[3] = 1'b0;
    chk(preg_q == preg_exp, "R6 preg clear one", int'(preg_q), int'(preg_exp));

    // R5 lock then immediately preload
    issue(3'd5, 0, '0, 1'b0, '0, 1, "R5 lock");
    issue(3'd4, 1, 16'h1, 1'b1, '0, 1, "R5 R4 preload after lock");
    drain();
    chk(lock_o == 1'b1, "R5 lock set", int'(lock_o), 1);
    chk(preg_q == preg_exp, "R4 R8 preg unchanged", int'(preg_q), int'(preg_exp));
    issue(3'd3, 5, '0, 1'b1, '0, 1, "R3 R8 verify locked");
    issue(3'd1, 1, '0, 1'b0, 16'h1234, 1, "R2 sig read locked");
    issue(3'd0, 1, 16'h7777, 1'b1, '0, 1, "R10 sig write locked");
    issue(3'd1, 1, '0, 1'b0, 16'h1234, 1, "R10 R8 sig kept");
    issue(3'd2, 5, 16'h4444, 1'b1, '0, 1, "R8 pat write locked");
    issue(3'd5, 0, '0, 1'b0, '0, 1, "R7 relock");
    drain();
    chk(lock_o == 1'b1, "R7 lock sticky", int'(lock_o), 1);

    // R7 erase clears lock and pattern
    issue(3'd6, 0, '0, 1'b0, '0, 1 + PATW, "R7 erase locked");
    drain();
    chk(lock_o == 1'b0, "R7 lock cleared", int'(lock_o), 0);
    issue(3'd3, 5, '0, 1'b0, 16'h0000, 1, "R7 pat wiped 5");
    issue(3'd3, 15, '0, 1'b0, 16'h0000, 1, "R7 pat wiped 15");
    issue(3'd4, 1, 16'h1, 1'b0, '0, 1, "R7 preload after erase");
    drain();
    preg_exp[1] = 1'b1;
    chk(preg_q == preg_exp, "R7 preload works", int'(preg_q), int'(preg_exp));
    chk(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule